// File: doc/BRIEF.md
# ADC Result Sequencer with Per-Position Compare

This block sits behind an analog converter that works through a sequence of conversions. Each finished sample arrives on a done strobe. A slot counter picks one of twelve result slots for it. Normally the sample is written into that slot. If compare is switched on for that position in the sequence, the slot instead holds a threshold that the host wrote earlier. The sample is then tested against that threshold, and a success sets the position's sticky flag. The slot itself is left as it was.

Compare is enabled by conversion position, not by input channel. A sense bit for each position sets the direction of the test: a sense of 1 means "greater than", and a sense of 0 means "less than or equal". The slot counter behaves differently in the two sequencing modes. In FIFO mode it carries on across sequence ends. Otherwise, the last conversion of a sequence returns it to zero. In both modes a sequence start, an abort, or a host write to the compare-enable register clears it. A write to that register also sends out an abort request to the converter.

The host reaches the block through a simple word-addressed register port. Reads are combinational and writes take effect at the clock edge.

Top module: `adc_result_sequencer`

## Requirements
- R1: After reset, every register reads zero and `abort_req` is low.
- R2: Each accepted conversion (`conv_done` high, with no start, abort or compare-enable write in the same cycle) advances the slot counter by one. The counter wraps from 11 to 0, so it never holds a value above 11.
- R3: With `fifo_mode` low, an accepted conversion that has `conv_last` high returns the counter to 0.
- R4: With `fifo_mode` high, `conv_last` has no effect on the counter. It keeps advancing and wrapping.
- R5: `seq_start` or `seq_abort` clears the counter in either mode. A conversion strobed in the same cycle is discarded and writes no slot.
- R6: A host write to the compare-enable register (address 0) clears the counter. It also drives `abort_req` high for exactly the following cycle.
- R7: When compare is disabled for the counter's position, an accepted conversion writes its sample into slot n, where n is the counter value.
- R8: When compare is enabled for position n (compare-enable bit n = 1), slot n keeps its threshold. Flag bit n is set if sense bit n = 1 and the sample is greater than the threshold. It is also set if sense bit n = 0 and the sample is less than or equal to the threshold.
- R9: Compare flags (address 2, bit n for position n) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R10: The counter register (address 3, bits 3:0) is read-only, and writes to it have no effect.
- R11: Register map: 0 holds compare-enable, 1 holds sense, 2 holds flags, 3 holds the counter, and 16+n holds slot n for n = 0..11. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_mode | input | 1 | 1: counter runs on across sequence ends |
| seq_start | input | 1 | Start of a new conversion sequence |
| seq_abort | input | 1 | Abort of the current sequence |
| conv_done | input | 1 | A conversion result is present on `conv_data` |
| conv_last | input | 1 | This conversion is the last of its sequence |
| conv_data | input | RES_W | Conversion result |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1: write, 0: read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| abort_req | output | 1 | One-cycle abort request after a compare-enable write |

## Verification
The bench uses the default parameters: twelve slots, a 4-bit counter and 12-bit results. With these values, fourteen conversions are enough to drive the counter across the 11-to-0 wrap. Twelve-bit thresholds allow exact tests at the equality boundary, where the two sense directions give different results. Each mode is exercised with both `fifo_mode` settings. Strobe collisions, such as a conversion arriving in the same cycle as an abort, are applied on purpose to check which event takes priority.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned REG_CMPE  = 0;
  localparam int unsigned REG_SENSE = 1;
  localparam int unsigned REG_FLAG  = 2;
  localparam int unsigned REG_CNT   = 3;
  localparam int unsigned SLOT_BASE = 16;
endpackage

// File: rtl/adcseq_counter.sv
module adcseq_counter #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             last,
  input  logic             fifo_mode,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (last && !fifo_mode) cnt_d = '0;
      else if (cnt_q == TOP)  cnt_d = '0;
      else                    cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && cnt_q == TOP) |=> cnt_q == '0);
  p_last_nonfifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && last && !fifo_mode) |=> cnt_q == '0);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/adcseq_slots.sv
module adcseq_slots #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RES_W     = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             conv_we,
  input  logic [CNT_W-1:0]                 cnt,
  input  logic [RES_W-1:0]                 conv_data,
  input  logic [NUM_SLOTS-1:0]             cmp_en,
  input  logic [NUM_SLOTS-1:0]             cmp_gt,
  input  logic [NUM_SLOTS-1:0]             slot_we,
  input  logic [RES_W-1:0]                 slot_wdata,
  input  logic [NUM_SLOTS-1:0]             flag_clr,
  output logic [NUM_SLOTS-1:0][RES_W-1:0]  slots,
  output logic [NUM_SLOTS-1:0]             flags
);
  logic [NUM_SLOTS-1:0][RES_W-1:0] slot_q, slot_d;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [NUM_SLOTS-1:0]            flag_q, flag_d, flag_set;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic here, hit, store;
    assign here  = conv_we && (cnt == CNT_W'(i));
    assign hit   = cmp_gt[i] ? (conv_data >  slot_q[i])
                             : (conv_data <= slot_q[i]);
    assign store = here && !cmp_en[i];
    assign flag_set[i] = here && cmp_en[i] && hit;

    always_comb begin
      slot_en[i] = store | slot_we[i];
      slot_d[i]  = store ? conv_data : slot_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_en[i]) slot_q[i] <= slot_d[i];
    end

    p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_we && cnt == CNT_W'(i) && !cmp_en[i]) |=> slot_q[i] == $past(conv_data));
    p_thresh_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_we && cnt == CNT_W'(i) && cmp_en[i] && !slot_we[i]) |=> $stable(slot_q[i]));
    p_flag_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_we && cnt == CNT_W'(i) && cmp_en[i] &&
       (cmp_gt[i] ? (conv_data > slot_q[i]) : (conv_data <= slot_q[i]))) |=> flag_q[i]);
    p_flag_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !flag_clr[i]) |=> flag_q[i]);
  end

  always_comb flag_d = (flag_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign slots = slot_q;
  assign flags = flag_q;
endmodule

// File: rtl/adcseq_regif.sv
module adcseq_regif
  import adcseq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_SLOTS-1:0][RES_W-1:0] slots,
  input  logic [NUM_SLOTS-1:0]            flags,
  output logic [NUM_SLOTS-1:0]            cmp_en,
  output logic [NUM_SLOTS-1:0]            cmp_gt,
  output logic [NUM_SLOTS-1:0]            slot_we,
  output logic [NUM_SLOTS-1:0]            flag_clr,
  output logic                            cmpe_wr,
  output logic                            abort_req
);
  logic                 wr;
  logic                 sense_wr;
  logic [NUM_SLOTS-1:0] cmpe_q, sense_q;
  logic                 abort_q;

  assign wr       = bus_sel && bus_wr;
  assign cmpe_wr  = wr && (bus_addr == ADDR_W'(REG_CMPE));
  assign sense_wr = wr && (bus_addr == ADDR_W'(REG_SENSE));
  assign flag_clr = (wr && (bus_addr == ADDR_W'(REG_FLAG))) ?
                    bus_wdata[NUM_SLOTS-1:0] : '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_we
    assign slot_we[i] = wr && (bus_addr == ADDR_W'(SLOT_BASE + i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmpe_q <= '0;
    else if (cmpe_wr) cmpe_q <= bus_wdata[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sense_q <= '0;
    else if (sense_wr) sense_q <= bus_wdata[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= cmpe_wr;
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(REG_CMPE))  bus_rdata = DATA_W'(cmpe_q);
    else if (bus_addr == ADDR_W'(REG_SENSE)) bus_rdata = DATA_W'(sense_q);
    else if (bus_addr == ADDR_W'(REG_FLAG))  bus_rdata = DATA_W'(flags);
    else if (bus_addr == ADDR_W'(REG_CNT))   bus_rdata = DATA_W'(cnt);
    else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (bus_addr == ADDR_W'(SLOT_BASE + i)) bus_rdata = DATA_W'(slots[i]);
    end
  end

  assign cmp_en    = cmpe_q;
  assign cmp_gt    = sense_q;
  assign abort_req = abort_q;

  p_abort_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmpe_wr |=> abort_req);
  p_abort_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpe_wr |=> !abort_req);
  p_slot_we_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
endmodule

// File: rtl/adc_result_sequencer.sv
module adc_result_sequencer #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned ADDR_W    = 5,
  localparam int unsigned DATA_W   = (RES_W > NUM_SLOTS) ? RES_W : NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              seq_start,
  input  logic              seq_abort,
  input  logic              conv_done,
  input  logic              conv_last,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              abort_req
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0]                cnt;
  logic [NUM_SLOTS-1:0][RES_W-1:0] slots;
  logic [NUM_SLOTS-1:0]            flags, cmp_en, cmp_gt, slot_we, flag_clr;
  logic                            cmpe_wr, clr_cnt, conv_we;

  assign clr_cnt = seq_start | seq_abort | cmpe_wr;
  assign conv_we = conv_done & ~clr_cnt;

  adcseq_counter #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_cnt), .adv(conv_we),
    .last(conv_last), .fifo_mode(fifo_mode), .cnt(cnt)
  );

  adcseq_slots #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .RES_W(RES_W)) u_slots (
    .clk(clk), .rst_n(rst_int_n), .conv_we(conv_we), .cnt(cnt),
    .conv_data(conv_data), .cmp_en(cmp_en), .cmp_gt(cmp_gt),
    .slot_we(slot_we), .slot_wdata(bus_wdata[RES_W-1:0]),
    .flag_clr(flag_clr), .slots(slots), .flags(flags)
  );

  adcseq_regif #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .RES_W(RES_W),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .slots(slots), .flags(flags), .cmp_en(cmp_en),
    .cmp_gt(cmp_gt), .slot_we(slot_we), .flag_clr(flag_clr),
    .cmpe_wr(cmpe_wr), .abort_req(abort_req)
  );

  initial begin
    a_geom_r2: assert (NUM_SLOTS <= (1 << CNT_W) && NUM_SLOTS <= 2**ADDR_W - 16);
  end

  p_discard_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (conv_done && (seq_start || seq_abort)) |=> cnt == '0);
endmodule

// File: tb/adc_result_sequencer_bench.sv
module adc_result_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 12;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, seq_start = 1'b0, seq_abort = 1'b0;
  logic conv_done = 1'b0, conv_last = 1'b0;
  logic [RW-1:0] conv_data = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic abort_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_sequencer u_adc_result_sequencer (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .seq_start(seq_start),
    .seq_abort(seq_abort), .conv_done(conv_done), .conv_last(conv_last),
    .conv_data(conv_data), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .abort_req(abort_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 12'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic expect_reg(input int a, input int exp, input string req);
    int v;
    reg_rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic conv(input int d, input bit last);
    @(negedge clk);
    conv_done = 1'b1; conv_data = RW'(d); conv_last = last;
    @(negedge clk);
    conv_done = 1'b0; conv_last = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
  endtask

  task automatic t_reset();
    expect_reg(0, 0, "R1 cmpe");
    expect_reg(1, 0, "R1 sense");
    expect_reg(2, 0, "R1 flags");
    expect_reg(3, 0, "R1 counter");
    expect_reg(16, 0, "R1 slot0");
    check(abort_req == 1'b0, "R1 abort_req", int'(abort_req), 0);
  endtask

  task automatic t_store();
    fifo_mode = 1'b0;
    pulse_start();
    conv(12'h111, 0);
    conv(12'h222, 0);
    expect_reg(3, 2, "R2 counter mid-sequence");
    conv(12'h333, 1);
    expect_reg(16, 12'h111, "R7 slot0");
    expect_reg(17, 12'h222, "R7 slot1");
    expect_reg(18, 12'h333, "R7 slot2");
    expect_reg(3, 0, "R3 counter after last");
  endtask

  task automatic t_wrap_fifo();
    fifo_mode = 1'b1;
    pulse_start();
    for (int i = 0; i < 14; i++) begin
      conv(12'h40 + i, i == 4);
      if (i == 4) expect_reg(3, 5, "R4 last ignored in fifo");
    end
    expect_reg(3, 2, "R2 wrap 11 to 0");
    expect_reg(27, 12'h4B, "R2 slot11");
    expect_reg(16, 12'h4C, "R2 slot0 after wrap");
    expect_reg(17, 12'h4D, "R2 slot1 after wrap");
  endtask

  task automatic t_start_abort();
    fifo_mode = 1'b1;
    pulse_start();
    expect_reg(3, 0, "R5 start clears in fifo");
    conv(12'h500, 0);
    conv(12'h501, 0);
    @(negedge clk);
    conv_done = 1'b1; conv_data = 12'hABC; seq_abort = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; seq_abort = 1'b0;
    expect_reg(3, 0, "R5 abort clears");
    expect_reg(18, 12'h42, "R5 conversion discarded");
  endtask

  task automatic t_cmpe_abort();
    int v;
    conv(12'h600, 0);
    expect_reg(3, 1, "R6 pre-count");
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(0); bus_wdata = 12'h0;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check(abort_req == 1'b1, "R6 abort_req high", int'(abort_req), 1);
    reg_rd(3, v);
    check(v == 0, "R6 counter cleared", v, 0);
    check(abort_req == 1'b0, "R6 abort_req one cycle", int'(abort_req), 0);
  endtask

  task automatic t_compare();
    fifo_mode = 1'b0;
    reg_wr(16, 100);
    reg_wr(17, 200);
    reg_wr(1, 12'h001);
    reg_wr(0, 12'h003);
    pulse_start();
    conv(150, 0);
    conv(250, 1);
    expect_reg(2, 1, "R8 gt hit, le miss");
    expect_reg(16, 100, "R8 threshold0 kept");
    expect_reg(17, 200, "R8 threshold1 kept");
    conv(50, 0);
    conv(200, 1);
    expect_reg(2, 3, "R8 le equal hits");
    reg_wr(2, 12'h003);
    conv(100, 1);
    expect_reg(2, 0, "R8 gt equal misses");
  endtask

  task automatic t_w1c();
    conv(150, 0);
    conv(10, 1);
    expect_reg(2, 3, "R9 flags set");
    reg_wr(2, 12'h000);
    expect_reg(2, 3, "R9 write 0 no effect");
    reg_wr(2, 12'h001);
    expect_reg(2, 2, "R9 w1c bit0");
  endtask

  task automatic t_ro();
    conv(12'h010, 0);
    reg_wr(3, 7);
    expect_reg(3, 1, "R10 counter read-only");
    expect_reg(1, 1, "R11 sense readback");
    expect_reg(0, 3, "R11 cmpe readback");
    expect_reg(5, 0, "R11 unmapped reads 0");
    expect_reg(28, 0, "R11 past last slot reads 0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_wrap_fifo();
    t_start_abort();
    t_cmpe_abort();
    t_compare();
    t_w1c();
    t_ro();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule